// File: doc/BRIEF.md
# Filtered PLL Lock Detector

This block sits behind a phase-frequency detector and decides whether the loop is locked. On every edge of a fast sampling clock it samples the detector's up and down error pulses. A one-cycle strobe marks the end of each comparison cycle. While either pulse is high the block counts sampling periods, and at the strobe it sorts the accumulated width into one of three bands: tight, middle or loose. The two band edges are parameters given in sampling-clock counts.

The filtered lock indication has asymmetric hysteresis. It is declared only after a run of consecutive tight comparison cycles. A single loose cycle withdraws it at once. A middle-band cycle changes nothing. Beside it, a raw status shows charge-pump activity as it happens: it is high while neither error pulse is active. A select input picks what the single lock-detect output carries. A power-down input forces every output low and discards all qualification, so lock has to be earned again once power-down ends.

Top module: `pll_lock_filter`

## Requirements
- R1: Error width is the number of sampling-clock edges at which `err_up_i` or `err_dn_i` is high, counted since the previous strobe. The edge on which `cmp_strobe_i` is high is included. Each strobe starts a new count at zero.
- R2: At a strobe, a width below `TIGHT_CNT` (default 3) is tight. After `GOOD_CYCLES` (default 5) consecutive tight strobes, `lock_filt_o` is high from the clock edge of the last of those strobes onward.
- R3: At a strobe, a width above `LOOSE_CNT` (default 6) is loose. A loose strobe drives `lock_filt_o` low at that edge and clears the run of tight strobes.
- R4: A width from `TIGHT_CNT` to `LOOSE_CNT` inclusive is middle-band. It neither advances nor clears the run of tight strobes, and it leaves `lock_filt_o` unchanged. Between strobes, `lock_filt_o` does not change.
- R5: The tight-run counter saturates at `GOOD_CYCLES`. Any number of further tight strobes keeps `lock_filt_o` high.
- R6: `lock_raw_o` is a registered copy of "no error pulse active". After an edge at which up or down is high it reads 0, and after an edge at which both are low it reads 1.
- R7: While `pwr_down_i` is high, `lock_filt_o`, `lock_raw_o` and `ld_out_o` are low in that same cycle, and the tight-run count is cleared. After power-down ends, `GOOD_CYCLES` new tight strobes are needed before lock is shown.
- R8: `ld_sel_i` encodes `ld_out_o`: 2'b00 gives constant 0, 2'b01 gives `lock_filt_o`, 2'b10 gives `lock_raw_o`, and 2'b11 gives constant 1 (1 only when not powered down).
- R9: While `rst_ni` is low and after reset, `lock_filt_o` and `lock_raw_o` are 0, and the tight-run count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| err_up_i | input | 1 | Up error pulse from the phase detector |
| err_dn_i | input | 1 | Down error pulse from the phase detector |
| cmp_strobe_i | input | 1 | One-cycle end-of-comparison strobe |
| pwr_down_i | input | 1 | PLL powered down; forces outputs low |
| ld_sel_i | input | 2 | Lock-detect output source select |
| lock_filt_o | output | 1 | Filtered lock with hysteresis |
| lock_raw_o | output | 1 | Raw lock from charge-pump activity |
| ld_out_o | output | 1 | Selected lock-detect output |

## Verification
Errors in the width accumulator or in the band decision show up at `lock_filt_o` within at most `GOOD_CYCLES` comparison cycles. Depending on the fault, lock is declared one strobe too early or too late, or a loose cycle fails to drop it. The bench runs a pseudo-random sweep of widths 0 to 9 across every band boundary and compares `lock_filt_o` against an arithmetic model after every strobe. The raw status and the output select are checked at every single clock, so a fault in either shows up within one cycle.

// File: rtl/pll_lock_pkg.sv
// Package: shared types for the filtered lock detector.
// Assumes: nothing beyond IEEE 1800-2017.
package pll_lock_pkg;

    // Band a measured error width falls into at a comparison strobe
    typedef enum logic [1:0] {
        BAND_TIGHT  = 2'b00,
        BAND_MIDDLE = 2'b01,
        BAND_LOOSE  = 2'b10
    } err_band_e;

    // Source select of the lock-detect output
    typedef enum logic [1:0] {
        LDSEL_ZERO = 2'b00,
        LDSEL_FILT = 2'b01,
        LDSEL_RAW  = 2'b10,
        LDSEL_ONE  = 2'b11
    } ld_sel_e;

endpackage

// File: rtl/err_width_meter.sv
// Module: err_width_meter
// Counts sampling edges with an active error pulse, starting again at each
// comparison strobe, and classifies the width seen at the strobe.
// Assumes: strobe is a single-cycle pulse; width saturates at LOOSE_CNT+1,
// which is enough to tell the loose band apart.
module err_width_meter
    import pll_lock_pkg::*;
#(
    parameter int TIGHT_CNT = 3,
    parameter int LOOSE_CNT = 6
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      active_i,
    input  logic      strobe_i,
    input  logic      clear_i,
    output err_band_e band_o
);
    localparam int MEAS_MAX = LOOSE_CNT + 1;
    localparam int MEAS_W   = $clog2(MEAS_MAX + 1) + 1;

    logic [MEAS_W-1:0] acc_q;
    logic [MEAS_W-1:0] meas;

    // Width including the current edge, saturated at MEAS_MAX
    always_comb begin
        meas = acc_q + MEAS_W'(active_i);
        if (meas > MEAS_W'(MEAS_MAX)) begin
            meas = MEAS_W'(MEAS_MAX);
        end
    end

    // Band decision on the width seen at this edge
    always_comb begin
        if (meas < MEAS_W'(TIGHT_CNT)) begin
            band_o = BAND_TIGHT;
        end else if (meas > MEAS_W'(LOOSE_CNT)) begin
            band_o = BAND_LOOSE;
        end else begin
            band_o = BAND_MIDDLE;
        end
    end

    // Accumulator: restarts at each strobe and during power-down
    always_ff @(posedge clk_i) begin
        if (!rst_ni || strobe_i || clear_i) begin
            acc_q <= '0;
        end else begin
            acc_q <= meas;
        end
    end
endmodule

// File: rtl/lock_qualifier.sv
// Module: lock_qualifier
// Keeps the run of consecutive tight strobes and the lock state. Lock is set
// when the run reaches GOOD_CYCLES and dropped by a single loose strobe.
// Assumes: band_i is meaningful only when strobe_i is high.
module lock_qualifier
    import pll_lock_pkg::*;
#(
    parameter int GOOD_CYCLES = 5
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      strobe_i,
    input  err_band_e band_i,
    input  logic      clear_i,
    output logic      lock_o
);
    localparam int RUN_W = $clog2(GOOD_CYCLES + 1);

    logic [RUN_W-1:0] run_q;
    logic             lock_q;

    // Run counter and lock flag, updated only at strobes
    always_ff @(posedge clk_i) begin
        if (!rst_ni || clear_i) begin
            run_q  <= '0;
            lock_q <= 1'b0;
        end else if (strobe_i) begin
            unique case (band_i)
                BAND_TIGHT: begin
                    if (run_q < RUN_W'(GOOD_CYCLES)) begin
                        run_q <= run_q + 1'b1;
                    end
                    if (run_q >= RUN_W'(GOOD_CYCLES - 1)) begin
                        lock_q <= 1'b1;
                    end
                end
                BAND_LOOSE: begin
                    run_q  <= '0;
                    lock_q <= 1'b0;
                end
                default: begin
                    run_q  <= run_q;
                    lock_q <= lock_q;
                end
            endcase
        end
    end

    assign lock_o = lock_q;
endmodule

// File: rtl/raw_activity.sv
// Module: raw_activity
// Registers the absence of charge-pump activity as a raw lock status.
// Assumes: up/down pulses are already synchronous to clk_i.
module raw_activity (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic active_i,
    input  logic clear_i,
    output logic raw_o
);
    logic raw_q;

    // High after an idle edge, low after an active edge
    always_ff @(posedge clk_i) begin
        if (!rst_ni || clear_i) begin
            raw_q <= 1'b0;
        end else begin
            raw_q <= !active_i;
        end
    end

    assign raw_o = raw_q;
endmodule

// File: rtl/pll_lock_filter.sv
// Module: pll_lock_filter (top)
// Filtered and raw PLL lock detection with a selectable lock-detect output
// and a power-down override that forces every output low.
// Assumes: all inputs synchronous to clk_i; thresholds in sampling counts.
module pll_lock_filter
    import pll_lock_pkg::*;
#(
    parameter int TIGHT_CNT   = 3,
    parameter int LOOSE_CNT   = 6,
    parameter int GOOD_CYCLES = 5
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       err_up_i,
    input  logic       err_dn_i,
    input  logic       cmp_strobe_i,
    input  logic       pwr_down_i,
    input  logic [1:0] ld_sel_i,
    output logic       lock_filt_o,
    output logic       lock_raw_o,
    output logic       ld_out_o
);
    logic      active;
    err_band_e band;
    logic      lock_q;
    logic      raw_q;
    logic      strobe_live;

    assign active      = err_up_i | err_dn_i;
    assign strobe_live = cmp_strobe_i & !pwr_down_i;

    err_width_meter #(
        .TIGHT_CNT(TIGHT_CNT),
        .LOOSE_CNT(LOOSE_CNT)
    ) u_meter (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .active_i(active),
        .strobe_i(cmp_strobe_i),
        .clear_i (pwr_down_i),
        .band_o  (band)
    );

    lock_qualifier #(
        .GOOD_CYCLES(GOOD_CYCLES)
    ) u_qual (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .strobe_i(strobe_live),
        .band_i  (band),
        .clear_i (pwr_down_i),
        .lock_o  (lock_q)
    );

    raw_activity u_raw (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .active_i(active),
        .clear_i (pwr_down_i),
        .raw_o   (raw_q)
    );

    assign lock_filt_o = lock_q & !pwr_down_i;
    assign lock_raw_o  = raw_q & !pwr_down_i;

    // Output source select, gated by power-down
    always_comb begin
        unique case (ld_sel_e'(ld_sel_i))
            LDSEL_ZERO: ld_out_o = 1'b0;
            LDSEL_FILT: ld_out_o = lock_filt_o;
            LDSEL_RAW:  ld_out_o = lock_raw_o;
            default:    ld_out_o = !pwr_down_i;
        endcase
    end
endmodule

// File: rtl/pll_lock_filter_chk.sv
// Module: pll_lock_filter_chk
// Port-level checker for pll_lock_filter, attached by bind below.
// Assumes: synchronous active-low reset; history valid one edge after reset.
module pll_lock_filter_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       err_up_i,
    input logic       err_dn_i,
    input logic       cmp_strobe_i,
    input logic       pwr_down_i,
    input logic [1:0] ld_sel_i,
    input logic       lock_filt_o,
    input logic       lock_raw_o,
    input logic       ld_out_o
);
    logic hist_q;

    // Marks that one edge has passed since reset, so $past is meaningful
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            hist_q <= 1'b0;
        end else begin
            hist_q <= 1'b1;
        end
    end

    assert_pd_forces_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwr_down_i |-> (!lock_filt_o && !lock_raw_o && !ld_out_o));

    assert_rise_at_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hist_q && $rose(lock_filt_o)) |-> $past(cmp_strobe_i));

    assert_fall_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hist_q && $fell(lock_filt_o)) |-> ($past(cmp_strobe_i) || $past(pwr_down_i) || pwr_down_i));

    assert_hold_between_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hist_q && !$past(cmp_strobe_i) && !$past(pwr_down_i) && !pwr_down_i) |-> $stable(lock_filt_o));

    assert_raw_tracks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hist_q && !pwr_down_i && !$past(pwr_down_i)) |-> (lock_raw_o == !$past(err_up_i || err_dn_i)));

    assert_sel_filt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ld_sel_i == 2'b01) |-> (ld_out_o == lock_filt_o));

    assert_sel_raw_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ld_sel_i == 2'b10) |-> (ld_out_o == lock_raw_o));
endmodule

bind pll_lock_filter pll_lock_filter_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .err_up_i    (err_up_i),
    .err_dn_i    (err_dn_i),
    .cmp_strobe_i(cmp_strobe_i),
    .pwr_down_i  (pwr_down_i),
    .ld_sel_i    (ld_sel_i),
    .lock_filt_o (lock_filt_o),
    .lock_raw_o  (lock_raw_o),
    .ld_out_o    (ld_out_o)
);

// File: tb/pll_lock_filter_test.sv
// Bench for pll_lock_filter: directed cases plus a pseudo-random width sweep,
// checked against an arithmetic model of the lock rules.
module pll_lock_filter_test;
    localparam int TIGHT = 3;
    localparam int LOOSE = 6;
    localparam int GOOD  = 5;
    localparam int CLEN  = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       up = 1'b0, dn = 1'b0, stb = 1'b0, pd = 1'b0;
    logic [1:0] sel = 2'b01;
    logic       filt, raw, ldo;

    int n_run = 0;
    int n_fail = 0;
    int m_run = 0;
    bit m_lock = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pll_lock_filter #(.TIGHT_CNT(TIGHT), .LOOSE_CNT(LOOSE), .GOOD_CYCLES(GOOD)) uut (
        .clk_i(clk), .rst_ni(rst_n), .err_up_i(up), .err_dn_i(dn),
        .cmp_strobe_i(stb), .pwr_down_i(pd), .ld_sel_i(sel),
        .lock_filt_o(filt), .lock_raw_o(raw), .ld_out_o(ldo)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Expected ld_out from select and model values
    function automatic logic sel_exp(input logic [1:0] s, input logic f, input logic r, input logic p);
        case (s)
            2'b00: return 1'b0;
            2'b01: return f;
            2'b10: return r;
            default: return !p;
        endcase
    endfunction

    // One comparison cycle: w active edges (alternating up/down), strobe on last edge
    task automatic comp_cycle(input int w);
        for (int i = 0; i < CLEN; i++) begin
            @(negedge clk);
            up  = (i < w) && (i % 2 == 0);
            dn  = (i < w) && (i % 2 == 1);
            stb = (i == CLEN - 1);
            @(posedge clk);
            #1;
            if (stb) begin
                if (w < TIGHT) begin
                    if (m_run < GOOD) m_run++;
                    if (m_run >= GOOD) m_lock = 1;
                end else if (w > LOOSE) begin
                    m_run = 0;
                    m_lock = 0;
                end
            end
            check("R6 raw", raw, !(i < w));
            check("R8 sel", ldo, sel_exp(sel, m_lock, !(i < w), 1'b0));
            if (!stb) check("R4 hold between strobes", filt, m_lock);
        end
        check("R1/R2/R3 filtered lock after strobe", filt, m_lock);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] lfsr;
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset filt", filt, 1'b0);
        check("R9 reset raw", raw, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: four tight cycles not enough, fifth locks
        for (int k = 0; k < GOOD - 1; k++) comp_cycle(TIGHT - 1);
        check("R2 no lock after GOOD-1", filt, 1'b0);
        comp_cycle(0);
        check("R2 lock after GOOD", filt, 1'b1);
        // R5 saturation
        for (int k = 0; k < 8; k++) comp_cycle(1);
        check("R5 stays locked", filt, 1'b1);
        // R4 middle band holds lock
        comp_cycle(TIGHT);
        comp_cycle(LOOSE);
        check("R4 middle holds lock", filt, 1'b1);
        // R3 single loose drops
        comp_cycle(LOOSE + 1);
        check("R3 loose drops lock", filt, 1'b0);
        // R4 middle does not clear run: 3 tight, middle, 2 tight -> lock
        for (int k = 0; k < 3; k++) comp_cycle(0);
        comp_cycle(LOOSE);
        check("R4 middle no lock", filt, 1'b0);
        comp_cycle(0);
        comp_cycle(0);
        check("R4 run kept across middle", filt, 1'b1);
        // R1: width boundary exactly TIGHT is not tight
        comp_cycle(LOOSE + 2);
        for (int k = 0; k < GOOD; k++) comp_cycle(TIGHT);
        check("R1 width TIGHT not tight", filt, 1'b0);

        // R7 power-down with lock
        for (int k = 0; k < GOOD; k++) comp_cycle(0);
        check("R7 locked before pd", filt, 1'b1);
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            pd = 1'b1;
            sel = 2'(s);
            up = 1'b0; dn = 1'b0; stb = 1'b0;
            #1;
            check("R7 pd filt low", filt, 1'b0);
            check("R7 pd raw low", raw, 1'b0);
            check("R7 pd ld_out low", ldo, 1'b0);
            @(posedge clk);
        end
        @(negedge clk);
        pd = 1'b0;
        sel = 2'b01;
        m_run = 0;
        m_lock = 0;
        for (int k = 0; k < GOOD - 1; k++) comp_cycle(0);
        check("R7 requalify needs GOOD", filt, 1'b0);
        comp_cycle(0);
        check("R7 requalified", filt, 1'b1);

        // Sweep: pseudo-random widths 0..9, rotating select
        lfsr = 8'hA5;
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            sel = 2'(k);
            comp_cycle(int'(lfsr) % 10);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule